// File: doc/BRIEF.md
# Eight-bit PWM Timer with Single- and Dual-Slope Modes

This block is a free-running 8-bit counter with a programmable clock divider and one compare channel that drives a waveform output. It has two waveform modes. In the single-slope mode the counter ramps up and wraps. In the dual-slope mode it ramps up to the top value and then back down, which keeps each pulse centred in its period. The compare value is written into a holding register. It is copied into the live compare register only at a fixed point of the period, so that a pulse that has already started is never cut short.

Software writes the mode, output polarity and divider select in one configuration write, and the compare value in a separate write. The block reports two sticky events: the end of a period (overflow) and a compare hit. Software clears each of them by writing 1 to its bit. The parameter `DUAL_EN` = 0 removes the down-count logic, and `cfg_dual` then has no effect.

Top module: `pwm_timer8`

## Requirements
- R1: Divider select `cfg_div` gives one counter step every 1, 8, 64, 256 or 1024 clocks for codes 1, 2, 3, 4, 5. Codes 0, 6 and 7 stop the counter. Every configuration write restarts the divider count, and no step happens in the cycle of that write.
- R2: With `cfg_dual` = 0 the counter steps 0, 1, …, 255 and then wraps to 0, so one period is 256 steps.
- R3: The overflow flag (`ovf_flag`) is set by the step taken at count 255 in single-slope mode, and by the step taken at count 0 in dual-slope mode.
- R4: The match flag (`match_flag`) is set by any step taken while the count equals the live compare value.
- R5: A `clr_we` write with `clr_mask` bit 0 = 1 clears `ovf_flag`, and with bit 1 = 1 clears `match_flag`. A 0 bit leaves its flag unchanged. A flag event in the same cycle wins over a clear.
- R6: Single-slope, `cfg_mode` = 2: the output goes high on the wrap step and low on a compare step. The output is therefore high for compare+1 of the 256 steps. `cfg_mode` = 3 gives the opposite levels.
- R7: Single-slope, `cfg_mode` = 1: the output inverts on every compare step. With compare 0 this gives two edges in 512 steps.
- R8: Single-slope with compare 0 gives a high pulse one step wide per period in mode 2. Compare 255 gives a constant high in mode 2 and a constant low in mode 3. The wrap action wins over the compare action.
- R9: A compare write goes to a holding register. The live value is loaded from it on the step taken at count 255, in both modes. A write made at the start of a period therefore only affects the next period.
- R10: With `cfg_dual` = 1 the counter steps 0 up to 255 and then down to 0, which makes a 510-step period.
- R11: Dual-slope, mode 2: a compare step on the way up drives the output low, and one on the way down drives it high. The step at 255 counts as down and the step at 0 counts as up. Compare 0x40 gives 128 high steps per period, compare 255 gives a constant high and compare 0 a constant low. Mode 3 gives the opposite levels, and mode 1 drives the output low.
- R12: `cfg_mode` = 0 holds `wave_out` low.
- R13: Synchronous reset clears the counter, both compare registers, the output and both flags, and selects the stopped divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dual | input | 1 | 1 selects the dual-slope counter |
| cfg_mode | input | 2 | Output mode: 0 off, 1 toggle, 2 low on match, 3 high on match |
| cfg_div | input | 3 | Divider select code |
| cmp_we | input | 1 | Compare holding-register write strobe |
| cmp_val | input | CNT_W (8) | Compare value |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 2 | Bit 0 clears overflow, bit 1 clears match |
| wave_out | output | 1 | Waveform output |
| ovf_flag | output | 1 | Sticky end-of-period flag |
| match_flag | output | 1 | Sticky compare-hit flag |

## Verification
Several properties are checked on every cycle: the divider never issues steps on consecutive cycles when its ratio is above one, the counter turns and wraps correctly, and the live compare value holds steady away from count 255. On every cycle the checks also confirm that the output reacts correctly at the wrap and at compare steps in each mode, and that the flags set on their events and clear on a clear write. Whole-period quantities come only from the bench's scenarios. These are the number of high steps for a given compare value, the 256- and 510-step periods, the effect of a compare write being delayed by one period, and the long divider intervals.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

   typedef enum logic [1:0] {
      PIN_OFF           = 2'd0,
      PIN_TOGGLE        = 2'd1,
      PIN_LOW_ON_MATCH  = 2'd2,
      PIN_HIGH_ON_MATCH = 2'd3
   } pin_mode_e;

   localparam int DIV_SEL_W = 3;

   function automatic logic div_active(input logic [DIV_SEL_W-1:0] sel);
      return (sel != 3'd0) && (sel <= 3'd5);
   endfunction

   // log2 of the divide ratio for each running select code
   function automatic logic [3:0] div_shift(input logic [DIV_SEL_W-1:0] sel);
      case (sel)
         3'd2:    return 4'd3;
         3'd3:    return 4'd6;
         3'd4:    return 4'd8;
         3'd5:    return 4'd10;
         default: return 4'd0;
      endcase
   endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
   import pwm_timer_pkg::*;
#(
   parameter int DIV_W = 10
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 restart,
   input  logic [DIV_SEL_W-1:0] sel,
   output logic                 tick
);

   if (DIV_W < 10) begin : g_div_w_chk
      $error("pwm_prescaler: DIV_W must hold a ratio of 1024");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] limit;
   logic             run;

   always_comb begin
      run   = div_active(sel);
      limit = (DIV_W'(1) << div_shift(sel)) - DIV_W'(1);
      tick  = run && !restart && (div_q == limit);
   end

   always_ff @(posedge clk) begin
      if (rst || restart || !run) begin
         div_q <= '0;
      end else if (tick) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + DIV_W'(1);
      end
   end

   // R1
   tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && (limit != '0)) |=> !tick);

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
   parameter int CNT_W   = 8,
   parameter bit DUAL_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             dual,
   output logic [CNT_W-1:0] cnt,
   output logic             down_move
);

   localparam logic [CNT_W-1:0] MAX    = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] MAX_M1 = MAX - CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   if (DUAL_EN) begin : g_dual
      logic dir_up_q;

      always_comb begin
         down_move = dual && (dir_up_q ? (cnt_q == MAX) : (cnt_q != '0));
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            dir_up_q <= 1'b1;
         end else if (tick) begin
            dir_up_q <= !down_move;
         end
      end

      // R10
      top_turn_chk: assert property (@(posedge clk) disable iff (rst)
         (tick && dual && dir_up_q && (cnt_q == MAX)) |=> (!dir_up_q && (cnt_q == MAX_M1)));

      // R10
      bottom_turn_chk: assert property (@(posedge clk) disable iff (rst)
         (tick && dual && !dir_up_q && (cnt_q == '0)) |=> (dir_up_q && (cnt_q == CNT_W'(1))));
   end else begin : g_single
      always_comb begin
         down_move = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= down_move ? cnt_q - CNT_W'(1) : cnt_q + CNT_W'(1);
      end
   end

   assign cnt = cnt_q;

   // R2
   wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && !down_move && (cnt_q == MAX)) |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
   import pwm_timer_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             dual,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] cnt,
   input  logic             down_move,
   input  logic             cmp_we,
   input  logic [CNT_W-1:0] cmp_val,
   output logic             match_hit,
   output logic             wave
);

   localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

   pin_mode_e        mode_e;
   logic [CNT_W-1:0] hold_q;
   logic [CNT_W-1:0] live_q;
   logic             at_max;
   logic             load;
   logic             pin_q;
   logic             pin_d;

   always_comb begin
      mode_e    = pin_mode_e'(mode);
      at_max    = (cnt == MAX);
      load      = tick && at_max;
      match_hit = tick && (cnt == live_q);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= '0;
         live_q <= '0;
      end else begin
         if (load)   live_q <= hold_q;
         if (cmp_we) hold_q <= cmp_val;
      end
   end

   always_comb begin
      pin_d = pin_q;
      if (tick) begin
         if (!dual) begin
            case (mode_e)
               PIN_TOGGLE:        if (match_hit) pin_d = !pin_q;
               PIN_LOW_ON_MATCH:  if (at_max) pin_d = 1'b1; else if (match_hit) pin_d = 1'b0;
               PIN_HIGH_ON_MATCH: if (at_max) pin_d = 1'b0; else if (match_hit) pin_d = 1'b1;
               default:           pin_d = pin_q;
            endcase
         end else begin
            case (mode_e)
               PIN_LOW_ON_MATCH:  if (match_hit) pin_d = down_move;
               PIN_HIGH_ON_MATCH: if (match_hit) pin_d = !down_move;
               default:           pin_d = pin_q;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) pin_q <= 1'b0;
      else     pin_q <= pin_d;
   end

   assign wave = ((mode_e == PIN_OFF) || (dual && (mode_e == PIN_TOGGLE))) ? 1'b0 : pin_q;

   // R9
   live_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(tick && at_max) |=> $stable(live_q));

   // R6
   wrap_set_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && at_max && !dual && (mode_e == PIN_LOW_ON_MATCH)) |=> pin_q);

   // R7
   toggle_chk: assert property (@(posedge clk) disable iff (rst)
      (match_hit && !dual && (mode_e == PIN_TOGGLE)) |=> (pin_q != $past(pin_q)));

   // R8
   full_scale_chk: assert property (@(posedge clk) disable iff (rst)
      (!dual && (mode_e == PIN_LOW_ON_MATCH) && (live_q == MAX) && pin_q) |=> pin_q);

   // R11
   upslope_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (match_hit && dual && !down_move && (mode_e == PIN_LOW_ON_MATCH)) |=> !pin_q);

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
   import pwm_timer_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int DIV_W   = 10,
   parameter bit DUAL_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_we,
   input  logic             cfg_dual,
   input  logic [1:0]       cfg_mode,
   input  logic [2:0]       cfg_div,
   input  logic             cmp_we,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             clr_we,
   input  logic [1:0]       clr_mask,
   output logic             wave_out,
   output logic             ovf_flag,
   output logic             match_flag
);

   if (CNT_W < 2 || CNT_W > 16) begin : g_cnt_w_chk
      $error("pwm_timer8: CNT_W must lie in 2..16");
   end

   localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

   logic             dual_q;
   logic [1:0]       mode_q;
   logic [2:0]       sel_q;
   logic             dual_eff;
   logic             tick;
   logic [CNT_W-1:0] cnt;
   logic             down_move;
   logic             match_hit;
   logic             ovf_ev;
   logic             ovf_q;
   logic             match_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         dual_q <= 1'b0;
         mode_q <= 2'd0;
         sel_q  <= 3'd0;
      end else if (cfg_we) begin
         dual_q <= cfg_dual;
         mode_q <= cfg_mode;
         sel_q  <= cfg_div;
      end
   end

   assign dual_eff = DUAL_EN && dual_q;

   pwm_prescaler #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst     (rst),
      .restart (cfg_we),
      .sel     (sel_q),
      .tick    (tick)
   );

   pwm_counter #(.CNT_W(CNT_W), .DUAL_EN(DUAL_EN)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .dual      (dual_eff),
      .cnt       (cnt),
      .down_move (down_move)
   );

   pwm_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .dual      (dual_eff),
      .mode      (mode_q),
      .cnt       (cnt),
      .down_move (down_move),
      .cmp_we    (cmp_we),
      .cmp_val   (cmp_val),
      .match_hit (match_hit),
      .wave      (wave_out)
   );

   assign ovf_ev = tick && (dual_eff ? (cnt == '0) : (cnt == MAX));

   always_ff @(posedge clk) begin
      if (rst) begin
         ovf_q   <= 1'b0;
         match_q <= 1'b0;
      end else begin
         ovf_q   <= ovf_ev    || (ovf_q   && !(clr_we && clr_mask[0]));
         match_q <= match_hit || (match_q && !(clr_we && clr_mask[1]));
      end
   end

   assign ovf_flag   = ovf_q;
   assign match_flag = match_q;

   // R3
   ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
      ovf_ev |=> ovf_flag);

   // R4
   match_set_chk: assert property (@(posedge clk) disable iff (rst)
      match_hit |=> match_flag);

   // R5
   ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_we && clr_mask[0] && !ovf_ev) |=> !ovf_flag);

   // R5
   match_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_we && clr_mask[1] && !match_hit) |=> !match_flag);

endmodule

// File: tb/pwm_timer8_bench.sv
module pwm_timer8_bench;

   logic       clk = 1'b0;
   logic       rst;
   logic       cfg_we, cfg_dual;
   logic [1:0] cfg_mode;
   logic [2:0] cfg_div;
   logic       cmp_we;
   logic [7:0] cmp_val;
   logic       clr_we;
   logic [1:0] clr_mask;
   logic       wave_out, ovf_flag, match_flag;

   always #5 clk = ~clk;

   pwm_timer8 u_pwm_timer8 (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_dual(cfg_dual),
      .cfg_mode(cfg_mode), .cfg_div(cfg_div), .cmp_we(cmp_we),
      .cmp_val(cmp_val), .clr_we(clr_we), .clr_mask(clr_mask),
      .wave_out(wave_out), .ovf_flag(ovf_flag), .match_flag(match_flag)
   );

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;
   bit chk_en  = 1'b0;

   // reference state, written from the requirements
   int m_div, m_cnt, m_hold, m_live, m_mode, m_sel;
   bit m_up, m_pin, m_ovf, m_mat, m_dual;

   function automatic int ratio_of(int s);
      case (s)
         1: return 1;
         2: return 8;
         3: return 64;
         4: return 256;
         5: return 1024;
         default: return 0;
      endcase
   endfunction

   function automatic bit exp_wave();
      if (m_mode == 0 || (m_dual && m_mode == 1)) return 1'b0;
      return m_pin;
   endfunction

   function automatic string wave_req();
      if (m_mode == 0) return "R12";
      if (m_dual)      return "R11";
      if (m_mode == 1) return "R7";
      return "R6";
   endfunction

   always @(posedge clk) begin : ref_model
      bit t, hit, dn, oev;
      int r;
      if (rst) begin
         m_div = 0; m_cnt = 0; m_hold = 0; m_live = 0; m_mode = 0; m_sel = 0;
         m_up = 1; m_pin = 0; m_ovf = 0; m_mat = 0; m_dual = 0;
      end else begin
         r = ratio_of(m_sel);
         t = 0; hit = 0; oev = 0;
         if (cfg_we) m_div = 0;
         else if (r != 0) begin
            if (m_div == r - 1) begin t = 1; m_div = 0; end
            else m_div = m_div + 1;
         end
         if (t) begin
            hit = (m_cnt == m_live);
            if (!m_dual) begin
               oev = (m_cnt == 255);
               case (m_mode)
                  1: if (hit) m_pin = !m_pin;
                  2: if (oev) m_pin = 1; else if (hit) m_pin = 0;
                  3: if (oev) m_pin = 0; else if (hit) m_pin = 1;
                  default: ;
               endcase
               if (m_cnt == 255) m_live = m_hold;
               m_cnt = (m_cnt + 1) % 256;
               m_up  = 1;
            end else begin
               dn  = m_up ? (m_cnt == 255) : (m_cnt != 0);
               oev = (m_cnt == 0);
               if (hit && m_mode == 2) m_pin = dn;
               if (hit && m_mode == 3) m_pin = !dn;
               if (m_cnt == 255) m_live = m_hold;
               m_cnt = dn ? m_cnt - 1 : m_cnt + 1;
               m_up  = !dn;
            end
         end
         m_ovf = oev || (m_ovf && !(clr_we && clr_mask[0]));
         m_mat = hit || (m_mat && !(clr_we && clr_mask[1]));
         if (cmp_we) m_hold = cmp_val;
         if (cfg_we) begin
            m_dual = cfg_dual; m_mode = cfg_mode; m_sel = cfg_div;
         end
      end
   end

   always @(negedge clk) begin
      if (chk_en && !done) begin
         vectors = vectors + 1;
         if (wave_out !== exp_wave()) begin
            errors = errors + 1;
            $display("FAIL %s wave_out act=%0b exp=%0b t=%0t", wave_req(), wave_out, exp_wave(), $time);
         end
         if (ovf_flag !== m_ovf) begin
            errors = errors + 1;
            $display("FAIL R3 ovf_flag act=%0b exp=%0b t=%0t", ovf_flag, m_ovf, $time);
         end
         if (match_flag !== m_mat) begin
            errors = errors + 1;
            $display("FAIL R4 match_flag act=%0b exp=%0b t=%0t", match_flag, m_mat, $time);
         end
      end
   end

   task automatic check(string req, int act, int exp);
      vectors = vectors + 1;
      if (act != exp) begin
         errors = errors + 1;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      cfg_we = 0; cmp_we = 0; clr_we = 0;
   endtask

   task automatic set_cfg(bit d, int m, int s);
      step();
      cfg_we = 1; cfg_dual = d; cfg_mode = m[1:0]; cfg_div = s[2:0];
   endtask

   task automatic set_cmp(int v);
      step();
      cmp_we = 1; cmp_val = v[7:0];
   endtask

   // returns at the first negedge of a period, with an overflow clear driven
   task automatic sync();
      int g;
      step();
      clr_we = 1; clr_mask = 2'b11;
      g = 0;
      do begin step(); g++; end while (!ovf_flag && g < 6000);
      check("R3 period start seen", int'(ovf_flag), 1);
      clr_we = 1; clr_mask = 2'b01;
   endtask

   task automatic measure(int n, output int highs, output int edges);
      bit prev;
      highs = int'(wave_out); edges = 0; prev = wave_out;
      for (int i = 1; i < n; i++) begin
         step();
         highs += int'(wave_out);
         if (wave_out != prev) edges++;
         prev = wave_out;
      end
   endtask

   task automatic interval(output int n);
      n = 0;
      do begin step(); n++; end while (!ovf_flag && n < 5000);
   endtask

   task automatic pwm_case(bit d, int m, int v, int n, string req, int exp_h);
      int h, e;
      set_cmp(v); set_cfg(d, m, 1);
      sync(); sync(); sync();
      measure(n, h, e);
      check(req, h, exp_h);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors = errors + 1;
         $display("FAIL watchdog act=expired exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin : main
      int h, e, n, x;
      rst = 1; cfg_we = 0; cfg_dual = 0; cfg_mode = 0; cfg_div = 0;
      cmp_we = 0; cmp_val = 0; clr_we = 0; clr_mask = 0;
      x = int'($urandom(32'h0C0FFEE5));
      repeat (3) @(negedge clk);
      // R13 reset state
      check("R13 wave after reset", int'(wave_out), 0);
      check("R13 ovf after reset", int'(ovf_flag), 0);
      check("R13 match after reset", int'(match_flag), 0);
      rst = 0; chk_en = 1;

      // R6 duty and R2 period
      pwm_case(0, 2, 8'h40, 256, "R6 mode2 highs", 65);
      sync(); interval(n); check("R2 single-slope period", n, 256);
      pwm_case(0, 3, 8'h40, 256, "R6 mode3 highs", 191);

      // R9 compare written at period start only acts on the next period
      set_cmp(8'h40); set_cfg(0, 2, 1); sync(); sync();
      cmp_we = 1; cmp_val = 8'hC0;
      measure(256, h, e); check("R9 old compare kept", h, 65);
      step(); measure(256, h, e); check("R9 new compare live", h, 193);

      // R8 extremes
      pwm_case(0, 2, 0, 256, "R8 compare 0 spike", 1);
      pwm_case(0, 2, 255, 256, "R8 compare 255 mode2", 256);
      pwm_case(0, 3, 255, 256, "R8 compare 255 mode3", 0);

      // R7 toggle
      set_cmp(0); set_cfg(0, 1, 1); sync(); sync();
      measure(512, h, e);
      check("R7 toggle edges", e, 2);
      check("R7 toggle highs", h, 256);

      // R11 and R10 dual slope
      pwm_case(1, 2, 8'h40, 510, "R11 dual mode2 highs", 128);
      sync(); interval(n); check("R10 dual-slope period", n, 510);
      pwm_case(1, 3, 8'h40, 510, "R11 dual mode3 highs", 382);
      pwm_case(1, 2, 255, 510, "R11 dual compare 255", 510);
      pwm_case(1, 2, 0, 510, "R11 dual compare 0", 0);
      pwm_case(1, 1, 8'h40, 510, "R11 dual mode1 low", 0);

      // R1 divide by 8
      set_cfg(0, 2, 2); sync(); interval(n);
      check("R1 divide-by-8 period", n, 2048);

      // R5 flag clears, with the divider stopped (R1)
      set_cmp(8'h10); set_cfg(0, 2, 1);
      repeat (600) step();
      set_cfg(0, 2, 0); step(); step();
      check("R3 ovf held", int'(ovf_flag), 1);
      check("R4 match held", int'(match_flag), 1);
      clr_we = 1; clr_mask = 2'b10; step(); step();
      check("R5 match cleared", int'(match_flag), 0);
      check("R5 ovf kept on mask bit0=0", int'(ovf_flag), 1);
      clr_we = 1; clr_mask = 2'b00; step(); step();
      check("R5 zero mask no effect", int'(ovf_flag), 1);
      clr_we = 1; clr_mask = 2'b01; step(); step();
      check("R5 ovf cleared", int'(ovf_flag), 0);
      repeat (3000) step();
      check("R1 stopped no ovf", int'(ovf_flag), 0);
      check("R1 stopped no match", int'(match_flag), 0);
      set_cfg(0, 2, 6); repeat (3000) step();
      check("R1 code 6 stopped", int'(ovf_flag) + int'(match_flag), 0);

      // R12 output off
      set_cmp(8'h40); set_cfg(0, 0, 1); step();
      measure(600, h, e); check("R12 mode0 low", h, 0);

      // constrained random traffic checked by the reference model every cycle
      for (int i = 0; i < 25000; i++) begin
         int r, pick;
         step();
         r = int'($urandom % 1000);
         if (r < 5) begin
            pick = int'($urandom % 6);
            cfg_we = 1; cfg_dual = 1'($urandom % 2); cfg_mode = 2'($urandom % 4);
            cfg_div = (pick == 3) ? 3'd2 : (pick == 4) ? 3'd0 : (pick == 5) ? 3'd6 : 3'd1;
         end
         if ((r % 20) == 0) begin
            pick = int'($urandom % 4);
            cmp_we = 1;
            cmp_val = (pick == 0) ? 8'd0 : (pick == 1) ? 8'd255 : 8'($urandom);
         end
         if ((r % 8) == 1) begin
            clr_we = 1; clr_mask = 2'($urandom % 4);
         end
      end
      step();

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule